// File: doc/BRIEF.md
# Vector Instruction Hazard Tracker

This block gives every accepted vector instruction an identifier drawn from a small pool of in-flight slots. For each slot it remembers which vector registers the instruction reads and which it writes. When a new instruction arrives, the block compares its register numbers with those of every live slot and produces a dependency vector. That vector becomes the new instruction's row in a square hazard matrix. The matrix is broadcast to the lanes' operand fetch logic, which can then chain operands element by element instead of waiting for whole registers.

Each slot is a two-state machine. `SLOT_FREE` moves to `SLOT_LIVE` on the ALLOC transition, when an accept strobe is taken while that slot is the chosen identifier. `SLOT_LIVE` moves back to `SLOT_FREE` on the RETIRE transition, when the slot's completion pulse arrives. A retiring slot drops out of every dependency in the same edge. An allocation in that same cycle never records a dependency on it.

Top module: `vec_hazard_tracker`

## Requirements
- R1: After an active-low reset, no slot is running, `idle_o` is 1, `hazard_o` is all zeros, `slot_avail_o` is 1 and `slot_id_o` is 0.
- R2: `slot_id_o` is the lowest-numbered slot not running. `slot_avail_o` is 1 exactly when at least one slot is not running.
- R3: An accepted issue sets the allocated slot's bit in `running_o` after the next clock edge. `idle_o` is 1 exactly when `running_o` is all zeros.
- R4: Read-after-write: bit j of `dep_vs1_o` (or of `dep_vs2_o`) is 1 when the corresponding source enable is 1, slot j is live and not completing this cycle, and slot j writes that source register.
- R5: Write-after-read: bit j of `dep_vd_o` is 1 when `vd_en_i` is 1, slot j is live and not completing, and slot j reads `vd_i`.
- R6: Write-after-write: bit j of `dep_vd_o` is 1 when `vd_en_i` is 1, slot j is live and not completing, and slot j writes `vd_i`.
- R7: Dependencies are reported separately for each operand on `dep_vs1_o`, `dep_vs2_o` and `dep_vd_o`, combinationally from the current inputs.
- R8: One edge after an accepted issue into slot i, row i of the matrix (`hazard_o[i*N +: N]`, bit j meaning "depends on slot j") equals the OR of the three operand dependency vectors.
- R9: A completion pulse on `done_i[j]` for a live slot clears its running bit, clears bit j in every row, and clears row j, all at the next edge. A completion pulse for a slot that is not running has no effect.
- R10: A completion and an accepted issue in the same cycle both take effect, and the new row has no bit set for the completing slot.
- R11: When no slot is free, `slot_avail_o` is 0 and an issue strobe changes neither `running_o` nor `hazard_o`.
- R12: No row of the matrix ever has its own diagonal bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Accept strobe for the presented instruction |
| vs1_i | input | REG_W | First source register number |
| vs1_en_i | input | 1 | First source is used |
| vs2_i | input | REG_W | Second source register number |
| vs2_en_i | input | 1 | Second source is used |
| vd_i | input | REG_W | Destination register number |
| vd_en_i | input | 1 | Destination is used |
| done_i | input | N | Per-slot completion pulses |
| slot_id_o | output | max(1,clog2(N)) | Identifier the next accepted instruction receives |
| slot_avail_o | output | 1 | A slot is free |
| dep_vs1_o | output | N | Slots the first source waits on |
| dep_vs2_o | output | N | Slots the second source waits on |
| dep_vd_o | output | N | Slots the destination waits on |
| hazard_o | output | N*N | Hazard matrix, row i at bits i*N +: N |
| running_o | output | N | Live-slot bitmap |
| idle_o | output | 1 | No slot live |

## Verification
The bench builds the tracker with N = 4 slots and 5-bit register numbers. With only four slots, the pool can be filled in four issues, so the full-pool stall and the ignored strobe are reached within a few cycles. The small pool also forces slot reuse right after a retirement, which is where a same-cycle completion and allocation meet. At that width the whole 16-bit matrix can be compared in every cycle against a bench model.

// File: rtl/vht_pkg.sv
package vht_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_LIVE = 1'b1
    } slot_state_e;

endpackage

// File: rtl/vht_alloc.sv
module vht_alloc #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = 3
) (
    input  logic [N-1:0]   busy_i,
    output logic [IDW-1:0] id_o,
    output logic           avail_o
);

    // trailing-zero count over the free map: lowest free slot wins
    always_comb begin
        id_o = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (!busy_i[i]) id_o = IDW'(i);
        end
        avail_o = ~&busy_i;
    end

endmodule

// File: rtl/vht_slot.sv
module vht_slot
    import vht_pkg::*;
#(
    parameter int unsigned N    = 8,
    parameter int unsigned IDX  = 0,
    parameter int unsigned NREG = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            alloc_i,
    input  logic            retire_i,
    input  logic [N-1:0]    done_vec_i,
    input  logic [NREG-1:0] q_vs1_i,
    input  logic [NREG-1:0] q_vs2_i,
    input  logic [NREG-1:0] q_vd_i,
    input  logic [N-1:0]    new_row_i,
    output logic            live_o,
    output logic            hit_vs1_o,
    output logic            hit_vs2_o,
    output logic            hit_vd_o,
    output logic [N-1:0]    row_o
);

    slot_state_e     state_q, state_d;
    logic [NREG-1:0] rd_q, wr_q;
    logic [N-1:0]    row_q;
    logic            counts;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc_i)  state_d = SLOT_LIVE;   // ALLOC
            SLOT_LIVE: if (retire_i) state_d = SLOT_FREE;   // RETIRE
            default:                 state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= SLOT_FREE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_q  <= '0;
            wr_q  <= '0;
            row_q <= '0;
        end else if (state_q == SLOT_FREE && alloc_i) begin
            rd_q  <= q_vs1_i | q_vs2_i;
            wr_q  <= q_vd_i;
            row_q <= new_row_i;
        end else if (state_q == SLOT_LIVE && retire_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            row_q <= '0;
        end else begin
            row_q <= row_q & ~done_vec_i;
        end
    end

    always_comb begin
        live_o    = (state_q == SLOT_LIVE);
        counts    = live_o && !retire_i;
        hit_vs1_o = counts && |(wr_q & q_vs1_i);
        hit_vs2_o = counts && |(wr_q & q_vs2_i);
        hit_vd_o  = counts && |((rd_q | wr_q) & q_vd_i);
        row_o     = row_q;
    end

    AST_FREE_ROW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SLOT_FREE) |-> (row_q == '0));                       // R9
    AST_NO_SELF_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !row_q[IDX]);                                                    // R12
    AST_RETIRE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SLOT_LIVE && retire_i) |=> (state_q == SLOT_FREE));  // R9
    AST_ALLOC_FREE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_i |-> (state_q == SLOT_FREE));                             // R2

endmodule

// File: rtl/vec_hazard_tracker.sv
module vec_hazard_tracker #(
    parameter int unsigned N     = 8,
    parameter int unsigned REG_W = 5,
    localparam int unsigned IDW  = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned NREG = 1 << REG_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             issue_i,
    input  logic [REG_W-1:0] vs1_i,
    input  logic             vs1_en_i,
    input  logic [REG_W-1:0] vs2_i,
    input  logic             vs2_en_i,
    input  logic [REG_W-1:0] vd_i,
    input  logic             vd_en_i,
    input  logic [N-1:0]     done_i,
    output logic [IDW-1:0]   slot_id_o,
    output logic             slot_avail_o,
    output logic [N-1:0]     dep_vs1_o,
    output logic [N-1:0]     dep_vs2_o,
    output logic [N-1:0]     dep_vd_o,
    output logic [N*N-1:0]   hazard_o,
    output logic [N-1:0]     running_o,
    output logic             idle_o
);

    logic [NREG-1:0] q_vs1, q_vs2, q_vd;
    logic [N-1:0]    new_row;
    logic            accept;

    always_comb begin
        q_vs1   = vs1_en_i ? (NREG'(1) << vs1_i) : '0;
        q_vs2   = vs2_en_i ? (NREG'(1) << vs2_i) : '0;
        q_vd    = vd_en_i  ? (NREG'(1) << vd_i)  : '0;
        new_row = dep_vs1_o | dep_vs2_o | dep_vd_o;
        accept  = issue_i && slot_avail_o;
        idle_o  = ~|running_o;
    end

    vht_alloc #(.N(N), .IDW(IDW)) u_alloc (
        .busy_i  (running_o),
        .id_o    (slot_id_o),
        .avail_o (slot_avail_o)
    );

    for (genvar g = 0; g < int'(N); g++) begin : g_slot
        vht_slot #(.N(N), .IDX(g), .NREG(NREG)) u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .alloc_i    (accept && (slot_id_o == IDW'(g))),
            .retire_i   (done_i[g]),
            .done_vec_i (done_i),
            .q_vs1_i    (q_vs1),
            .q_vs2_i    (q_vs2),
            .q_vd_i     (q_vd),
            .new_row_i  (new_row),
            .live_o     (running_o[g]),
            .hit_vs1_o  (dep_vs1_o[g]),
            .hit_vs2_o  (dep_vs2_o[g]),
            .hit_vd_o   (dep_vd_o[g]),
            .row_o      (hazard_o[g*N +: N])
        );

        AST_ROW_LIVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((hazard_o[g*N +: N] & ~running_o) == '0));                  // R9
    end

    AST_ACCEPT_SETS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> running_o[$past(slot_id_o)]);                         // R3
    AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !slot_avail_o) |=> (running_o == $past(running_o & ~done_i))); // R11
    AST_NO_RETIRING_DEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((new_row & done_i) == '0));                                     // R10

endmodule

// File: tb/test_vec_hazard_tracker.sv
`timescale 1ns/1ps
module test_vec_hazard_tracker;

    localparam int NS = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          issue;
    logic [4:0]    vs1, vs2, vd;
    logic          vs1_en, vs2_en, vd_en;
    logic [NS-1:0] done;
    logic [IW-1:0] slot_id;
    logic          slot_avail;
    logic [NS-1:0] dep1, dep2, depd;
    logic [NS*NS-1:0] hazard;
    logic [NS-1:0] running;
    logic          idle;

    always #4 clk = ~clk;

    vec_hazard_tracker #(.N(NS), .REG_W(5)) i_vec_hazard_tracker (
        .clk_i(clk), .rst_ni(rst_n), .issue_i(issue),
        .vs1_i(vs1), .vs1_en_i(vs1_en), .vs2_i(vs2), .vs2_en_i(vs2_en),
        .vd_i(vd), .vd_en_i(vd_en), .done_i(done),
        .slot_id_o(slot_id), .slot_avail_o(slot_avail),
        .dep_vs1_o(dep1), .dep_vs2_o(dep2), .dep_vd_o(depd),
        .hazard_o(hazard), .running_o(running), .idle_o(idle)
    );

    typedef struct {
        logic [NS-1:0]    run;
        logic [NS*NS-1:0] mat;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 0;

    logic [31:0]   m_rd[NS];
    logic [31:0]   m_wr[NS];
    logic [NS-1:0] m_row[NS];
    logic [NS-1:0] m_run;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: pops the expected state and compares the registered outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [NS*NS-1:0] diag;
            e = exp_q.pop_front();
            diag = '0;
            for (int i = 0; i < NS; i++) diag[i*NS + i] = 1'b1;
            check(running === e.run, {e.tag, " R3 running"}, 64'(running), 64'(e.run));
            check(hazard === e.mat, {e.tag, " R8/R9 matrix"}, 64'(hazard), 64'(e.mat));
            check(idle === (e.run == '0), {e.tag, " R3 idle"}, 64'(idle), 64'(e.run == '0));
            check((hazard & diag) == '0, {e.tag, " R12 diagonal"}, 64'(hazard & diag), 64'd0);
        end
    end

    // driver: drives one cycle, checks combinational outputs, pushes expected state
    task automatic step(input logic iss, input logic [4:0] a, input logic ae,
                        input logic [4:0] b, input logic be,
                        input logic [4:0] d, input logic de,
                        input logic [NS-1:0] dn, input string tag);
        int eid;
        logic [NS-1:0] e1, e2, ed;
        exp_t e;
        @(negedge clk); #2;
        issue = iss; vs1 = a; vs1_en = ae; vs2 = b; vs2_en = be;
        vd = d; vd_en = de; done = dn;
        #1;
        eid = -1;
        for (int j = 0; j < NS; j++) if (!m_run[j] && eid < 0) eid = j;
        check(slot_avail === (eid >= 0), {tag, " R2/R11 avail"}, 64'(slot_avail), 64'(eid >= 0));
        if (eid >= 0)
            check(slot_id === IW'(eid), {tag, " R2 id"}, 64'(slot_id), 64'(eid));
        for (int j = 0; j < NS; j++) begin
            bit lv;
            lv = m_run[j] && !dn[j];
            e1[j] = lv && ae && m_wr[j][a];
            e2[j] = lv && be && m_wr[j][b];
            ed[j] = lv && de && (m_rd[j][d] || m_wr[j][d]);
        end
        check(dep1 === e1, {tag, " R4/R7 vs1"}, 64'(dep1), 64'(e1));
        check(dep2 === e2, {tag, " R4/R7 vs2"}, 64'(dep2), 64'(e2));
        check(depd === ed, {tag, " R5/R6/R7 vd"}, 64'(depd), 64'(ed));
        for (int j = 0; j < NS; j++) begin
            if (m_run[j] && dn[j]) begin
                m_run[j] = 1'b0; m_rd[j] = '0; m_wr[j] = '0; m_row[j] = '0;
                for (int k = 0; k < NS; k++) m_row[k][j] = 1'b0;
            end
        end
        if (iss && eid >= 0) begin
            m_run[eid] = 1'b1;
            m_rd[eid]  = (ae ? (32'd1 << a) : 32'd0) | (be ? (32'd1 << b) : 32'd0);
            m_wr[eid]  = de ? (32'd1 << d) : 32'd0;
            m_row[eid] = e1 | e2 | ed;
        end
        e.run = m_run;
        e.tag = tag;
        for (int i = 0; i < NS; i++) e.mat[i*NS +: NS] = m_row[i];
        exp_q.push_back(e);
        @(posedge clk); #1;
        issue = 1'b0; done = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; issue = 1'b0; done = '0;
        vs1 = '0; vs2 = '0; vd = '0; vs1_en = 0; vs2_en = 0; vd_en = 0;
        m_run = '0;
        for (int i = 0; i < NS; i++) begin m_rd[i] = '0; m_wr[i] = '0; m_row[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(running === '0, "R1 running", 64'(running), 64'd0);
        check(hazard === '0, "R1 matrix", 64'(hazard), 64'd0);
        check(idle === 1'b1, "R1 idle", 64'(idle), 64'd1);
        check(slot_avail === 1'b1, "R1 avail", 64'(slot_avail), 64'd1);
        check(slot_id === '0, "R1 id", 64'(slot_id), 64'd0);

        step(1, 5'd2, 1, 5'd3, 1, 5'd1, 1, 4'b0000, "R3 first");
        step(1, 5'd1, 1, 5'd5, 1, 5'd4, 1, 4'b0000, "R4 raw");
        step(1, 5'd6, 1, 5'd7, 1, 5'd2, 1, 4'b0000, "R5 war");
        step(1, 5'd8, 1, 5'd0, 0, 5'd4, 1, 4'b0000, "R6 waw");
        step(1, 5'd1, 1, 5'd0, 0, 5'd9, 1, 4'b0000, "R11 full");
        step(0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 4'b0001, "R9 retire");
        // R10: slot1 completes while a new instruction takes slot0
        step(1, 5'd4, 1, 5'd2, 1, 5'd10, 1, 4'b0010, "R10 same-cycle");
        step(0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 4'b0010, "R9 free-done");
        step(1, 5'd11, 1, 5'd12, 0, 5'd4, 0, 4'b0000, "R2 reuse");
        step(0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 4'b1111, "R9 drain");
        step(0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 4'b0000, "R3 idle");
        @(negedge clk);
        #2;
        finish_run();
    end

endmodule